// File: doc/BRIEF.md
# Address-Space ID Rollover Manager

This block hands out address-space identifiers for a translation cache whose storage is split into two equal banks. A request to invalidate an address space is answered by issuing the next identifier, not by searching the cache for old entries. Entries tagged with an earlier identifier become stale, and a later miss may overwrite them. One bank is active: lookups and fills use it. The other bank is being scrubbed. Each time an identifier is issued, the block also zeroes a small fixed run of entries in the scrubbed bank, one entry per clock.

The run length is the bank depth divided by the number of identifiers, rounded up. With that length the scrubbed bank is fully zeroed by the time the counter wraps. On the wrap the identifier returns to 0 and the two banks swap roles. A full-cache flush pause therefore never occurs. After a synchronous reset the block zeroes both banks completely and then starts with identifier 0 on bank 0.

The request side is a valid/ready handshake. The requester raises `req_valid` and must hold it until it sees `req_ready`. The block keeps `req_ready` low while it is zeroing, and raises it for exactly one cycle after the run for that request has finished. A transfer happens on a clock edge where both signals are high. Back-pressure is never dropped: a request that arrives during any zeroing is held off, not lost.

Top module: `asid_rollover_mgr`

## Requirements
- R1: While reset is high: `asid` is 0, `bank_sel` is 0, `err` is 0 and `req_ready` is 0.
- R2: In the cycles after reset falls, `clr_we` is 2'b11 for exactly ENTRIES consecutive cycles, with `clr_idx` running 0, 1, … ENTRIES-1. Any two back-to-back write cycles always use consecutive indices.
- R3: A request held high during the post-reset zeroing sees `req_ready` stay 0 until that zeroing ends. It is then served normally.
- R4: A request seen in the idle state gets `req_ready` high exactly SLICE+1 cycles later. After the transfer, `asid` is the previous value plus one (except at a wrap).
- R5: Outside the post-reset zeroing, `clr_we[bank_sel]` is never 1. Zeroing writes go only to the inactive bank, whose bit is `clr_we[~bank_sel]`. Their indices continue upward from where the previous run stopped and end at ENTRIES-1.
- R6: A transfer while `asid` is 2^ASID_W-1 sets `asid` to 0, inverts `bank_sel`, and restarts zeroing of the new inactive bank at index 0.
- R7: `err` goes high and stays high if a wrap occurs while the inactive bank still has entries left to zero. With the run length of R9 this never happens.
- R8: `asid` and `bank_sel` change only on a clock edge with `req_valid` and `req_ready` both high.
- R9: Each request zeroes at most SLICE = ceil(ENTRIES / 2^ASID_W) entries. Once the bank is fully zeroed, a request writes nothing but still takes SLICE+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | New-identifier request; held until accepted |
| req_ready | output | 1 | Request accepted on this edge (zeroing run done) |
| asid | output | ASID_W | Current address-space identifier |
| bank_sel | output | 1 | Active bank (0 or 1) |
| clr_we | output | 2 | Per-bank zero-write enable |
| clr_idx | output | $clog2(ENTRIES) | Entry index being zeroed |
| err | output | 1 | Sticky: banks swapped with zeroing incomplete |

## Verification
The critical coincidence is the wrap. On that transfer the identifier returns to 0 and the banks swap. In the same cycle the "inactive bank fully zeroed" check is taken, and the zeroing pointer is reset for the other bank. The bench provokes this with a small identifier width and a bank depth that is not a multiple of the identifier count. The last non-empty run is then short, and the run that follows it is empty. The test runs two full epochs and judges the result by three things: `err` stays low, the new inactive bank is written starting at index 0, and the previously active bank is never written.

// File: rtl/asr_pkg.sv
package asr_pkg;
  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_SLICE = 2'd2,
    ST_GRANT = 2'd3
  } asr_state_e;
endpackage

// File: rtl/asr_sweep.sv
module asr_sweep #(
  parameter int ENTRIES = 128,
  parameter int IW = $clog2(ENTRIES),
  parameter int PW = $clog2(ENTRIES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          both,
  input  logic          bank_sel,
  input  logic          restart,
  output logic [1:0]    wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          clean,
  output logic          last
);
  localparam logic [PW-1:0] FULL = PW'(ENTRIES);
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

  logic [PW-1:0] ptr;
  logic          can_wr;

  assign can_wr = step && (ptr < FULL);
  assign clean  = (ptr == FULL);
  assign last   = (ptr == LAST);
  assign wr_idx = ptr[IW-1:0];

  always_comb begin
    if (both)          wr_en = {2{can_wr}};
    else if (bank_sel) wr_en = {1'b0, can_wr};
    else               wr_en = {can_wr, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst)          ptr <= '0;
    else if (restart) ptr <= '0;
    else if (can_wr)  ptr <= ptr + 1'b1;
  end

  // R2: consecutive write cycles walk the index upward by one
  p_idx_seq_r2: assert property (@(posedge clk) disable iff (rst)
    ((|wr_en) && $past(|wr_en)) |-> (wr_idx == $past(wr_idx) + 1'b1));
endmodule

// File: rtl/asr_epoch.sv
module asr_epoch #(
  parameter int ASID_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant,
  input  logic              clean,
  output logic [ASID_W-1:0] asid,
  output logic              bank_sel,
  output logic              err,
  output logic              wrap
);
  localparam logic [ASID_W-1:0] TOP_ID = '1;

  assign wrap = grant && (asid == TOP_ID);

  always_ff @(posedge clk) begin
    if (rst) begin
      asid     <= '0;
      bank_sel <= 1'b0;
      err      <= 1'b0;
    end else if (wrap) begin
      asid     <= '0;
      bank_sel <= ~bank_sel;
      if (!clean) err <= 1'b1;
    end else if (grant) begin
      asid <= asid + 1'b1;
    end
  end

  p_asid_step_r4: assert property (@(posedge clk) disable iff (rst)
    (grant && asid != TOP_ID) |=> (asid == $past(asid) + 1'b1) && $stable(bank_sel));

  p_wrap_swap_r6: assert property (@(posedge clk) disable iff (rst)
    (grant && asid == TOP_ID) |=> (asid == '0) && (bank_sel != $past(bank_sel)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !grant |=> $stable(asid) && $stable(bank_sel));
endmodule

// File: rtl/asid_rollover_mgr.sv
module asid_rollover_mgr
  import asr_pkg::*;
#(
  parameter int ASID_W  = 6,
  parameter int ENTRIES = 128,
  parameter int IW      = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  output logic [ASID_W-1:0] asid,
  output logic              bank_sel,
  output logic [1:0]        clr_we,
  output logic [IW-1:0]     clr_idx,
  output logic              err
);
  localparam int NUM_ID = 1 << ASID_W;
  localparam int SLICE  = (ENTRIES + NUM_ID - 1) / NUM_ID;
  localparam int SW     = $clog2(SLICE) + 1;
  localparam logic [SW-1:0] SLICE_END = SW'(SLICE - 1);

  asr_state_e    state;
  logic [SW-1:0] scnt;
  logic          step, grant, clean, last, wrap;

  assign req_ready = (state == ST_GRANT);
  assign grant     = req_ready && req_valid;
  assign step      = !rst && (state == ST_INIT || state == ST_SLICE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_INIT;
      scnt  <= '0;
    end else begin
      unique case (state)
        ST_INIT:  if (last) state <= ST_IDLE;
        ST_IDLE:  if (req_valid) begin
                    state <= ST_SLICE;
                    scnt  <= '0;
                  end
        ST_SLICE: begin
                    scnt <= scnt + 1'b1;
                    if (scnt == SLICE_END) state <= ST_GRANT;
                  end
        ST_GRANT: if (req_valid) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  asr_sweep #(.ENTRIES(ENTRIES), .IW(IW)) u_sweep (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .both     (state == ST_INIT),
    .bank_sel (bank_sel),
    .restart  (wrap),
    .wr_en    (clr_we),
    .wr_idx   (clr_idx),
    .clean    (clean),
    .last     (last)
  );

  asr_epoch #(.ASID_W(ASID_W)) u_epoch (
    .clk      (clk),
    .rst      (rst),
    .grant    (grant),
    .clean    (clean),
    .asid     (asid),
    .bank_sel (bank_sel),
    .err      (err),
    .wrap     (wrap)
  );

  p_active_untouched_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_INIT) |-> !clr_we[bank_sel]);

  p_swap_clean_r7: assert property (@(posedge clk) disable iff (rst)
    wrap |-> clean);

  p_init_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (|clr_we && clr_we[bank_sel]) |-> !req_ready);
endmodule

// File: tb/asid_rollover_mgr_test.sv
module asid_rollover_mgr_test;
  localparam int AW = 3;
  localparam int N  = 20;
  localparam int IW = $clog2(N);
  localparam int SLICE = (N + (1 << AW) - 1) / (1 << AW);

  // {gap cycles, asid after, bank after, writes in this request}
  localparam logic [31:0] TBL [0:16] = '{
    {8'd0, 8'd1, 8'd0, 8'd0}, {8'd1, 8'd2, 8'd0, 8'd0}, {8'd2, 8'd3, 8'd0, 8'd0},
    {8'd0, 8'd4, 8'd0, 8'd0}, {8'd3, 8'd5, 8'd0, 8'd0}, {8'd0, 8'd6, 8'd0, 8'd0},
    {8'd1, 8'd7, 8'd0, 8'd0}, {8'd0, 8'd0, 8'd1, 8'd0}, {8'd2, 8'd1, 8'd1, 8'd3},
    {8'd0, 8'd2, 8'd1, 8'd3}, {8'd1, 8'd3, 8'd1, 8'd3}, {8'd0, 8'd4, 8'd1, 8'd3},
    {8'd3, 8'd5, 8'd1, 8'd3}, {8'd0, 8'd6, 8'd1, 8'd3}, {8'd0, 8'd7, 8'd1, 8'd2},
    {8'd1, 8'd0, 8'd0, 8'd0}, {8'd0, 8'd1, 8'd0, 8'd3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] asid;
  logic bank_sel;
  logic [1:0] clr_we;
  logic [IW-1:0] clr_idx;
  logic err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int mptr;
  logic mbank;

  always #10 clk = ~clk;

  asid_rollover_mgr #(.ASID_W(AW), .ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .asid(asid), .bank_sel(bank_sel), .clr_we(clr_we), .clr_idx(clr_idx), .err(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  task automatic do_req(input int gap, input int e_asid, input int e_bank, input int e_wr);
    int k = 0;
    int wr = 0;
    bit bad_bank = 1'b0;
    bit bad_idx = 1'b0;
    req_valid = 1'b0;
    repeat (gap) @(negedge clk);
    req_valid = 1'b1;
    forever begin
      #1;
      if (clr_we[mbank]) bad_bank = 1'b1;
      if (clr_we[~mbank]) begin
        if (int'(clr_idx) != mptr) bad_idx = 1'b1;
        mptr++;
        wr++;
      end
      if (req_ready) break;
      @(negedge clk);
      k++;
    end
    chk(k == SLICE + 1, "R4 ready latency", k, SLICE + 1);
    chk(wr == e_wr, "R9 writes per request", wr, e_wr);
    chk(!bad_bank, "R5 active bank written", bad_bank, 0);
    chk(!bad_idx, "R5 index order", bad_idx, 0);
    @(negedge clk);
    #1;
    chk(int'(asid) == e_asid, "R4 R6 asid", asid, e_asid);
    chk(int'(bank_sel) == e_bank, "R6 bank", bank_sel, e_bank);
    chk(!err, "R7 err", err, 0);
    if (bank_sel != mbank) begin
      mbank = bank_sel;
      mptr = 0;
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(asid == 0 && bank_sel == 0, "R1 asid/bank", {asid, bank_sel}, 0);
    chk(!err && !req_ready, "R1 err/ready", {err, req_ready}, 0);
    chk(clr_we == 2'b00, "R1 no writes in reset", clr_we, 0);
    @(negedge clk);
    rst = 1'b0;
    // R2: full zeroing of both banks
    for (int i = 0; i < N; i++) begin
      #1;
      chk(clr_we == 2'b11 && int'(clr_idx) == i, "R2 init sweep", {clr_we, clr_idx}, {2'b11, i[IW-1:0]});
      @(negedge clk);
    end
    #1;
    chk(clr_we == 2'b00, "R2 init ends", clr_we, 0);
    mptr = N;
    mbank = 1'b0;
    // Table walk: two full epochs plus one
    for (int t = 0; t < 17; t++)
      do_req(int'(TBL[t][31:24]), int'(TBL[t][23:16]), int'(TBL[t][15:8]), int'(TBL[t][7:0]));
    req_valid = 1'b0;
    // R8: idle cycles leave asid/bank alone
    repeat (5) @(negedge clk);
    #1;
    chk(asid == 1 && bank_sel == 0, "R8 hold when idle", {asid, bank_sel}, {3'd1, 1'b0});
    // R3: request held through reset zeroing is stalled, then served
    rst = 1'b1;
    req_valid = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    begin
      int k = 0;
      bit early = 1'b0;
      forever begin
        #1;
        if (req_ready) break;
        if (clr_we == 2'b11 && req_ready) early = 1'b1;
        @(negedge clk);
        k++;
      end
      chk(k == N + SLICE + 1, "R3 stall length", k, N + SLICE + 1);
      chk(!early, "R3 ready during init", early, 0);
    end
    @(negedge clk);
    #1;
    chk(asid == 1 && bank_sel == 0, "R3 served after stall", {asid, bank_sel}, {3'd1, 1'b0});
    req_valid = 1'b0;
    chk(!err, "R7 err final", err, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule